// File: doc/BRIEF.md
# Wide Cascaded Programmable Divider Chain

This block is a wide synchronous binary counter assembled from a row of narrow presettable counter stages (8 bits each by default, four stages for a 32-bit chain). Each stage raises an active-low all-ones flag. Glue logic ORs the flags of all lower stages, together with a global active-low count enable, into each higher stage's active-low count enable. A stage therefore advances only on the edge where every stage below it sits at all ones. On that same edge the lower stages roll over to zero, their flags return high, and the higher stage drops back to hold.

In divider mode a single shared OR of every stage's flag drives all of the stages' parallel-load inputs. The whole chain reloads its preset only in the cycle when every bit is one. No stage reloads on its own. With a preset of 2^W − N, the chain output goes low for one clock in every N clocks, for any N from 2 to 2^W.

A synchronous active-low load request also plants the preset directly. This is the only way to start a wide chain at a known value without first counting through its whole range. The stage count and stage width are parameters. Two carry-glue variants are available: a ripple form and a flat form.

Top module: `wide_div_chain`

## Requirements
- R1: While `rst_n` is low, `count` is all zeros and `tc_n` is high; the reset acts without a clock edge.
- R2: With `chain_en_n` low and no load taking place, `count` advances by one per rising edge as a single W-bit binary number. Carries cross stage boundaries on the same edge: 0x000000FF becomes 0x00000100.
- R3: With `chain_en_n` high and no load taking place, `count` holds its value.
- R4: `tc_n` is low exactly when every bit of `count` is one.
- R5: `sync_load_n` low at a rising edge loads `preset` into `count`. This takes priority over counting and happens whatever the values of `chain_en_n` and `div_mode`.
- R6: With `div_mode` = 1, a rising edge at which `count` is all ones loads `preset` into `count`, even when `chain_en_n` is high.
- R7: With `div_mode` = 0, counting past all ones wraps `count` to zero.
- R8: In divider mode with counting enabled and `preset` = 2^W − N, `tc_n` is low for exactly one clock in every N clocks. This holds for N = 2, 3, 256, 257 and 65536.
- R9: `NUM_STAGES` must be at least 2 and `STAGE_W` at least 1, checked at elaboration. A 2-stage chain built with the flat carry glue behaves to the same rules as a 4-stage chain built with the ripple glue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en_n | input | 1 | Active-low global count enable |
| sync_load_n | input | 1 | Active-low synchronous load request |
| div_mode | input | 1 | 1 = chain-wide reload at all ones (divider), 0 = free count |
| preset | input | STAGE_W*NUM_STAGES | Parallel preset value |
| count | output | STAGE_W*NUM_STAGES | Current chain count |
| tc_n | output | 1 | Active-low chain terminal count / divided output |

## Verification
The hardest conditions to reach from the ports are the carries into the upper stages and the chain-wide terminal count of a 32-bit chain. Counting up from reset would take about 2^32 clocks. The stimulus uses the synchronous load to plant the count just below a stage boundary (0xFD, 0xFFFE) and just below full wrap. It then runs divide ratios that force the reload through one stage, two stages and all stages, up to a ratio of 65536. A behavioural reference model of the same width is compared against the count and `tc_n` on every clock, for both a 4-stage and a 2-stage instance.

// File: rtl/divchain_pkg.sv
package divchain_pkg;
   typedef enum logic {
      MODE_COUNT  = 1'b0,
      MODE_DIVIDE = 1'b1
   } chain_mode_e;

   localparam int unsigned DEF_STAGE_W    = 8;
   localparam int unsigned DEF_NUM_STAGES = 4;
endpackage

// File: rtl/divchain_stage.sv
module divchain_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             cen_n,
   input  logic [WIDTH-1:0] preset,
   output logic [WIDTH-1:0] q,
   output logic             tc_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (!load_n) q <= preset;
      else if (!cen_n)  q <= q + 1'b1;
   end

   // active-low all-ones flag, decoded from the stage's own state
   assign tc_n = ~(&q);
endmodule

// File: rtl/divchain_carry.sv
module divchain_carry #(
   parameter int unsigned NUM_STAGES = 4,
   parameter bit          LOOKAHEAD  = 1'b0
) (
   input  logic                  chain_en_n,
   input  logic [NUM_STAGES-2:0] lower_tc_n,
   output logic [NUM_STAGES-1:0] stage_cen_n
);
   if (LOOKAHEAD) begin : g_flat
      // each enable is one wide OR of the chain enable and all lower flags
      always_comb begin
         for (int i = 0; i < NUM_STAGES; i++) begin
            stage_cen_n[i] = chain_en_n;
            for (int j = 0; j < i; j++) stage_cen_n[i] |= lower_tc_n[j];
         end
      end
   end else begin : g_ripple
      // each enable reuses the one below it plus a single new flag
      assign stage_cen_n[0] = chain_en_n;
      for (genvar i = 1; i < NUM_STAGES; i++) begin : g_link
         assign stage_cen_n[i] = stage_cen_n[i-1] | lower_tc_n[i-1];
      end
   end
endmodule

// File: rtl/divchain_reload.sv
module divchain_reload
   import divchain_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 4
) (
   input  logic [NUM_STAGES-1:0] stage_tc_n,
   input  logic                  sync_load_n,
   input  chain_mode_e           mode,
   output logic                  chain_tc_n,
   output logic                  shared_load_n
);
   // low only when every stage flag is low, i.e. the whole chain is all ones
   assign chain_tc_n = |stage_tc_n;

   always_comb begin
      shared_load_n = sync_load_n;
      if (mode == MODE_DIVIDE) shared_load_n = sync_load_n & chain_tc_n;
   end
endmodule

// File: rtl/wide_div_chain.sv
module wide_div_chain
   import divchain_pkg::*;
#(
   parameter int unsigned STAGE_W    = DEF_STAGE_W,
   parameter int unsigned NUM_STAGES = DEF_NUM_STAGES,
   parameter bit          LOOKAHEAD  = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            chain_en_n,
   input  logic                            sync_load_n,
   input  logic                            div_mode,
   input  logic [STAGE_W*NUM_STAGES-1:0]   preset,
   output logic [STAGE_W*NUM_STAGES-1:0]   count,
   output logic                            tc_n
);
   localparam int unsigned COUNT_W = STAGE_W * NUM_STAGES;

   // R9: elaboration-time parameter checks
   if (NUM_STAGES < 2) begin : g_bad_stages
      $error("wide_div_chain: NUM_STAGES must be at least 2 (R9)");
   end
   if (STAGE_W < 1) begin : g_bad_width
      $error("wide_div_chain: STAGE_W must be at least 1 (R9)");
   end

   logic [NUM_STAGES-1:0] stage_tc_n;
   logic [NUM_STAGES-1:0] stage_cen_n;
   logic                  shared_load_n;
   logic                  chain_tc_n;

   divchain_carry #(
      .NUM_STAGES (NUM_STAGES),
      .LOOKAHEAD  (LOOKAHEAD)
   ) u_carry (
      .chain_en_n  (chain_en_n),
      .lower_tc_n  (stage_tc_n[NUM_STAGES-2:0]),
      .stage_cen_n (stage_cen_n)
   );

   divchain_reload #(
      .NUM_STAGES (NUM_STAGES)
   ) u_reload (
      .stage_tc_n    (stage_tc_n),
      .sync_load_n   (sync_load_n),
      .mode          (chain_mode_e'(div_mode)),
      .chain_tc_n    (chain_tc_n),
      .shared_load_n (shared_load_n)
   );

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      divchain_stage #(
         .WIDTH (STAGE_W)
      ) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_n (shared_load_n),
         .cen_n  (stage_cen_n[s]),
         .preset (preset[s*STAGE_W +: STAGE_W]),
         .q      (count[s*STAGE_W +: STAGE_W]),
         .tc_n   (stage_tc_n[s])
      );
   end

   assign tc_n = chain_tc_n;
endmodule

// File: rtl/wide_div_chain_chk.sv
module wide_div_chain_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         chain_en_n,
   input logic         sync_load_n,
   input logic         div_mode,
   input logic [W-1:0] preset,
   input logic [W-1:0] count,
   input logic         tc_n
);
   localparam logic [W-1:0] ALL_ONES = '1;

   logic full;
   assign full = (count == ALL_ONES);

   always @(negedge clk) begin
      if (!rst_n) assert_reset_R1: assert (count == '0 && tc_n);
   end

   assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_en_n && sync_load_n && !(div_mode && full))
         |=> count == W'($past(count) + 1'b1));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_en_n && sync_load_n && !(div_mode && full)) |=> $stable(count));

   assert_tcflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      full == !tc_n);

   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_load_n |=> count == $past(preset));

   assert_divreload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (div_mode && full) |=> count == $past(preset));

   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_mode && full && sync_load_n && !chain_en_n) |=> count == '0);
endmodule

bind wide_div_chain wide_div_chain_chk #(.W(COUNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chain_en_n  (chain_en_n),
   .sync_load_n (sync_load_n),
   .div_mode    (div_mode),
   .preset      (preset),
   .count       (count),
   .tc_n        (tc_n)
);

// File: tb/wide_div_chain_tb.sv
module wide_div_chain_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        chain_en_n = 1'b1;
   logic        sync_load_n = 1'b1;
   logic        div_mode = 1'b0;
   logic [31:0] preset = '0;
   logic [31:0] cnt4;
   logic [15:0] cnt2;
   logic        tc4, tc2;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   // 4 stages, ripple carry glue
   wide_div_chain #(.STAGE_W(8), .NUM_STAGES(4), .LOOKAHEAD(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .chain_en_n(chain_en_n), .sync_load_n(sync_load_n),
      .div_mode(div_mode), .preset(preset), .count(cnt4), .tc_n(tc4));

   // 2 stages, flat carry glue (R9)
   wide_div_chain #(.STAGE_W(8), .NUM_STAGES(2), .LOOKAHEAD(1'b1)) u_dut_s2 (
      .clk(clk), .rst_n(rst_n), .chain_en_n(chain_en_n), .sync_load_n(sync_load_n),
      .div_mode(div_mode), .preset(preset[15:0]), .count(cnt2), .tc_n(tc2));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference models
   logic [31:0] m4;
   logic [15:0] m2;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m4 <= 0;
         m2 <= 0;
      end else begin
         if (!sync_load_n || (div_mode && m4 == 32'hFFFF_FFFF)) m4 <= preset;
         else if (!chain_en_n) m4 <= m4 + 1;
         if (!sync_load_n || (div_mode && m2 == 16'hFFFF)) m2 <= preset[15:0];
         else if (!chain_en_n) m2 <= m2 + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 count model 4-stage", cnt4, m4);
         check("R4 flag model 4-stage", tc4, m4 != 32'hFFFF_FFFF);
         check("R9 count model 2-stage", cnt2, m2);
         check("R4 flag model 2-stage", tc2, m2 != 16'hFFFF);
      end
   end

   task automatic load_value(input logic [31:0] v);
      preset = v;
      sync_load_n = 1'b0;
      @(negedge clk);
      sync_load_n = 1'b1;
   endtask

   task automatic measure(input int n);
      int seen4 = 0, seen2 = 0, first4 = 0, first2 = 0, per4 = -1, per2 = -1;
      int w4 = -1, w2 = -1;
      for (int cyc = 1; cyc < 3 * n + 20; cyc++) begin
         @(negedge clk);
         if (seen4 == 1 && cyc == first4 + 1) w4 = tc4;
         if (seen2 == 1 && cyc == first2 + 1) w2 = tc2;
         if (!tc4 && seen4 < 2) begin
            if (seen4 == 1) per4 = cyc - first4;
            else first4 = cyc;
            seen4++;
         end
         if (!tc2 && seen2 < 2) begin
            if (seen2 == 1) per2 = cyc - first2;
            else first2 = cyc;
            seen2++;
         end
         if (seen4 == 2 && seen2 == 2) break;
      end
      check("R8 period 4-stage", per4, n);
      check("R8 period 2-stage", per2, n);
      check("R8 low width 4-stage", w4, 1);
      check("R8 low width 2-stage", w2, 1);
   endtask

   initial begin
      int ratios[5] = '{2, 3, 256, 257, 65536};
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset count", cnt4, 0);
      check("R1 reset tc_n", tc4, 1);
      check("R1 reset count 2-stage", cnt2, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: load honoured while count enable is off
      load_value(32'h0000_00FD);
      check("R5 load with enable off", cnt4, 32'h0000_00FD);

      // R2: carry across the first stage boundary
      chain_en_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R2 carry into stage 1", cnt4, 32'h0000_0102);
      check("R2 carry 2-stage", cnt2, 16'h0102);

      // R3: hold
      chain_en_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R3 hold", cnt4, 32'h0000_0102);

      // R2: carry across two boundaries at once
      load_value(32'h0000_FFFE);
      chain_en_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 carry into stage 2", cnt4, 32'h0001_0000);

      // R4 / R7: full wrap in count mode
      chain_en_n = 1'b1;
      load_value(32'hFFFF_FFFE);
      chain_en_n = 1'b0;
      @(negedge clk);
      check("R4 tc_n low at all ones", tc4, 0);
      @(negedge clk);
      check("R7 wrap to zero", cnt4, 0);
      check("R4 tc_n high after wrap", tc4, 1);

      // R6: divider reload with enable off
      chain_en_n = 1'b1;
      div_mode = 1'b1;
      load_value(32'hFFFF_FFFF);
      preset = 32'h1234_5678;
      @(negedge clk);
      check("R6 reload with enable off", cnt4, 32'h1234_5678);
      check("R6 reload 2-stage", cnt2, 16'h5678);

      // R8: divide ratios
      chain_en_n = 1'b0;
      foreach (ratios[k]) begin
         logic [32:0] p;
         p = 33'h1_0000_0000 - 33'(ratios[k]);
         load_value(p[31:0]);
         measure(ratios[k]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule